// File: doc/BRIEF.md
# Interrupt and Subroutine Context Stack Sequencer

This block is the part of an 8-bit processor core that moves machine context between the register set and a byte-wide stack in memory. It holds the program counter, the accumulator, the low byte of the index register, the condition-code register and a 16-bit stack pointer. On a start pulse it runs one of four stack operations: a software interrupt, a return from interrupt, a return from subroutine, or a stack-pointer reset. It raises `done` on the last cycle of the operation.

It drives a synchronous byte memory port. The address, write data and write enable are presented in a cycle, and read data comes back one cycle later. Each operation runs for a fixed number of cycles, with idle cycles inserted where needed, so the surrounding core can count on an exact latency. Instruction fetch, operand addressing and arithmetic are handled elsewhere.

Top module: `ctx_stack_seq`

## Requirements
- R1: Software interrupt (op code 0x83) first adds one to PC. In cycles 2 through 6 after start it writes low PC, high PC, index, accumulator and CCR, in that order. The first byte goes to address SP, and SP drops by one after each write, so SP ends five lower.
- R2: After the five writes, the software interrupt sets CCR bit 3 (the interrupt mask). It then reads the new high PC byte from address VEC_ADDR and the new low PC byte from VEC_ADDR+1.
- R3: Return from interrupt (op code 0x80) adds one to SP before each of five reads. It restores the whole CCR, then the accumulator, then the index, then high PC, then low PC, so SP ends five higher.
- R4: Return from subroutine (op code 0x81) reads high PC from SP+1 and low PC from SP+2, and leaves SP two higher. The accumulator, index and CCR do not change.
- R5: Stack reset (op code 0x9C) sets SP bits 7:0 to 0xFF and keeps SP bits 15:8. It completes in one cycle, with done high in cycle 1 after start.
- R6: Counting the cycle after the start edge as cycle 1, done is high only in cycle 11 for the software interrupt, cycle 9 for return from interrupt, cycle 6 for return from subroutine and cycle 1 for stack reset. It stays high for exactly one cycle.
- R7: Any other op code gives done in cycle 1. It writes no memory and changes no register.
- R8: After reset, PC is RESET_PC (0x0000), the accumulator and index are 0x00, CCR is RESET_CCR (0x08), SP is RESET_SP (0x00FF), and done and mem_we are low.
- R9: A memory write is issued only during the five push cycles of a software interrupt, and each write goes to the current SP. Read data is taken one cycle after its address.
- R10: A start pulse that arrives while a sequence is running is ignored. The running sequence keeps its length and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_code | input | 8 | Operation selector, sampled with start |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |
| done | output | 1 | One-cycle pulse on the final cycle of an operation |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| idx_o | output | 8 | Index register low byte |
| ccr_o | output | 8 | Condition-code register |
| sp_o | output | 16 | Stack pointer |

## Verification
The assertions assume that start is raised for a single cycle with a defined op code, and that the memory returns the byte at the registered address one cycle later. The bench's memory model provides exactly that: a sparse byte store with one-cycle read latency. The stimulus reaches stack pointers whose high byte is non-zero through the pulls of a return from interrupt, so the stack-reset check can tell a kept high byte from a cleared one. It raises a second start inside a running sequence only to test that it is ignored.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 4;
    localparam int CCR_MASK_BIT = 3;

    localparam logic [7:0] OPC_SWI = 8'h83;
    localparam logic [7:0] OPC_RTI = 8'h80;
    localparam logic [7:0] OPC_RTS = 8'h81;
    localparam logic [7:0] OPC_RSP = 8'h9C;

    localparam logic [STEP_W-1:0] LEN_SWI = 4'd11;
    localparam logic [STEP_W-1:0] LEN_RTI = 4'd9;
    localparam logic [STEP_W-1:0] LEN_RTS = 4'd6;
    localparam logic [STEP_W-1:0] LEN_ONE = 4'd1;

    typedef enum logic [2:0] {K_NONE, K_SWI, K_RTI, K_RTS, K_RSP, K_BAD} kind_e;
    typedef enum logic [1:0] {BUS_IDLE, BUS_WR, BUS_RD} bus_e;
    typedef enum logic [1:0] {ADR_SP, ADR_SP_NEXT, ADR_VEC_HI, ADR_VEC_LO} adr_e;
    typedef enum logic [2:0] {R_NONE, R_PCL, R_PCH, R_X, R_A, R_CCR} reg_e;

    typedef struct packed {
        bus_e bus;
        adr_e adr;
        reg_e wsel;
    } bus_req_t;

    typedef struct packed {
        reg_e cap;
        logic sp_dec;
        logic sp_inc;
        logic pc_inc;
        logic set_mask;
        logic sp_low_fill;
    } upd_t;

    typedef struct packed {
        bus_req_t req;
        upd_t     upd;
        logic     last;
    } action_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] ccr;
        logic [ADDR_W-1:0] sp;
    } ctx_t;

    function automatic kind_e decode_op(input logic [7:0] op);
        kind_e k;
        case (op)
            OPC_SWI: k = K_SWI;
            OPC_RTI: k = K_RTI;
            OPC_RTS: k = K_RTS;
            OPC_RSP: k = K_RSP;
            default: k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic action_t act_push(input reg_e r);
        action_t a;
        a = '0;
        a.req.bus  = BUS_WR;
        a.req.adr  = ADR_SP;
        a.req.wsel = r;
        a.upd.sp_dec = 1'b1;
        return a;
    endfunction

    // pre-increment read; 'prev' captures the byte requested one cycle earlier
    function automatic action_t act_pull(input reg_e prev);
        action_t a;
        a = '0;
        a.req.bus = BUS_RD;
        a.req.adr = ADR_SP_NEXT;
        a.upd.sp_inc = 1'b1;
        a.upd.cap = prev;
        return a;
    endfunction

    function automatic action_t step_action(input kind_e k, input logic [STEP_W-1:0] s);
        action_t a;
        a = '0;
        case (k)
            K_SWI: begin
                case (s)
                    4'd1: a.upd.pc_inc = 1'b1;
                    4'd2: a = act_push(R_PCL);
                    4'd3: a = act_push(R_PCH);
                    4'd4: a = act_push(R_X);
                    4'd5: a = act_push(R_A);
                    4'd6: a = act_push(R_CCR);
                    4'd7: begin
                        a.upd.set_mask = 1'b1;
                        a.req.bus = BUS_RD;
                        a.req.adr = ADR_VEC_HI;
                    end
                    4'd8: begin
                        a.req.bus = BUS_RD;
                        a.req.adr = ADR_VEC_LO;
                        a.upd.cap = R_PCH;
                    end
                    4'd9: a.upd.cap = R_PCL;
                    default: ;
                endcase
                a.last = (s == LEN_SWI);
            end
            K_RTI: begin
                case (s)
                    4'd2: a = act_pull(R_NONE);
                    4'd3: a = act_pull(R_CCR);
                    4'd4: a = act_pull(R_A);
                    4'd5: a = act_pull(R_X);
                    4'd6: a = act_pull(R_PCH);
                    4'd7: a.upd.cap = R_PCL;
                    default: ;
                endcase
                a.last = (s == LEN_RTI);
            end
            K_RTS: begin
                case (s)
                    4'd2: a = act_pull(R_NONE);
                    4'd3: a = act_pull(R_PCH);
                    4'd4: a.upd.cap = R_PCL;
                    default: ;
                endcase
                a.last = (s == LEN_RTS);
            end
            K_RSP: begin
                a.upd.sp_low_fill = 1'b1;
                a.last = (s == LEN_ONE);
            end
            K_BAD: a.last = (s == LEN_ONE);
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] op,
    output action_t    act,
    output logic       done
);

    logic              running_q;
    kind_e             kind_q;
    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            kind_q    <= K_NONE;
            step_q    <= '0;
        end else if (!running_q) begin
            if (start) begin
                running_q <= 1'b1;
                kind_q    <= decode_op(op);
                step_q    <= {{(STEP_W-1){1'b0}}, 1'b1};
            end
        end else if (act.last) begin
            running_q <= 1'b0;
            step_q    <= '0;
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        act = running_q ? step_action(kind_q, step_q) : '0;
    end

    assign done = act.last;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_q && start && op == OPC_RSP) |=> done);

    // R7
    bad_op_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_q && start && decode_op(op) == K_BAD) |=> (done && !act.req.bus[0]));

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
    import ctx_stack_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC  = 16'h0000,
    parameter logic [ADDR_W-1:0] RESET_SP  = 16'h00FF,
    parameter logic [DATA_W-1:0] RESET_CCR = 8'h08
)(
    input  logic              clk,
    input  logic              rst,
    input  upd_t              upd,
    input  logic [DATA_W-1:0] rdata,
    output ctx_t              ctx
);

    localparam int HALF = ADDR_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.pc  <= RESET_PC;
            ctx.a   <= '0;
            ctx.x   <= '0;
            ctx.ccr <= RESET_CCR;
            ctx.sp  <= RESET_SP;
        end else begin
            if (upd.pc_inc)      ctx.pc <= ctx.pc + 1'b1;
            if (upd.sp_dec)      ctx.sp <= ctx.sp - 1'b1;
            if (upd.sp_inc)      ctx.sp <= ctx.sp + 1'b1;
            if (upd.sp_low_fill) ctx.sp[HALF-1:0] <= '1;
            if (upd.set_mask)    ctx.ccr[CCR_MASK_BIT] <= 1'b1;
            case (upd.cap)
                R_PCL:   ctx.pc[HALF-1:0]      <= rdata;
                R_PCH:   ctx.pc[ADDR_W-1:HALF] <= rdata;
                R_X:     ctx.x                 <= rdata;
                R_A:     ctx.a                 <= rdata;
                R_CCR:   ctx.ccr               <= rdata;
                default: ;
            endcase
        end
    end

    // R5
    rsp_high_keep_chk: assert property (@(posedge clk) disable iff (rst)
        upd.sp_low_fill |=> (ctx.sp == {$past(ctx.sp[ADDR_W-1:HALF]), {HALF{1'b1}}}));

endmodule

// File: rtl/ctx_bus_port.sv
module ctx_bus_port
    import ctx_stack_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
)(
    input  bus_req_t          req,
    input  ctx_t              ctx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we
);

    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = VEC_ADDR + 1'b1;

    always_comb begin
        case (req.adr)
            ADR_SP:      addr = ctx.sp;
            ADR_SP_NEXT: addr = ctx.sp + 1'b1;
            ADR_VEC_HI:  addr = VEC_ADDR;
            default:     addr = VEC_LO_ADDR;
        endcase
    end

    always_comb begin
        case (req.wsel)
            R_PCL:   wdata = ctx.pc[DATA_W-1:0];
            R_PCH:   wdata = ctx.pc[ADDR_W-1:DATA_W];
            R_X:     wdata = ctx.x;
            R_A:     wdata = ctx.a;
            R_CCR:   wdata = ctx.ccr;
            default: wdata = '0;
        endcase
    end

    assign we = (req.bus == BUS_WR);

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR  = 16'hFFFC,
    parameter logic [15:0] RESET_PC  = 16'h0000,
    parameter logic [15:0] RESET_SP  = 16'h00FF,
    parameter logic [7:0]  RESET_CCR = 8'h08
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  op_code,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic        done,
    output logic [15:0] pc_o,
    output logic [7:0]  acc_o,
    output logic [7:0]  idx_o,
    output logic [7:0]  ccr_o,
    output logic [15:0] sp_o
);

    action_t act;
    ctx_t    ctx;

    ctx_seq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op_code),
        .act   (act),
        .done  (done)
    );

    ctx_regfile #(
        .RESET_PC  (RESET_PC),
        .RESET_SP  (RESET_SP),
        .RESET_CCR (RESET_CCR)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .upd   (act.upd),
        .rdata (mem_rdata),
        .ctx   (ctx)
    );

    ctx_bus_port #(
        .VEC_ADDR (VEC_ADDR)
    ) u_bus (
        .req   (act.req),
        .ctx   (ctx),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .we    (mem_we)
    );

    assign pc_o  = ctx.pc;
    assign acc_o = ctx.a;
    assign idx_o = ctx.x;
    assign ccr_o = ctx.ccr;
    assign sp_o  = ctx.sp;

    // R9
    push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == sp_o));

    // R1
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_o == $past(sp_o) - 16'd1));

endmodule

// File: tb/ctx_stack_seq_bench.sv
module ctx_stack_seq_bench;

    localparam logic [15:0] VEC = 16'hFFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic        done;
    logic [15:0] pc_o, sp_o;
    logic [7:0]  acc_o, idx_o, ccr_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit [7:0] mem [bit [15:0]];

    // reference context
    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_a, m_x, m_ccr;

    always #5 clk = ~clk;

    ctx_stack_seq #(
        .VEC_ADDR (VEC), .RESET_PC (16'h0000), .RESET_SP (16'h00FF), .RESET_CCR (8'h08)
    ) u_ctx_stack_seq (
        .clk (clk), .rst (rst), .start (start), .op_code (op_code),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
        .mem_rdata (mem_rdata), .done (done), .pc_o (pc_o), .acc_o (acc_o),
        .idx_o (idx_o), .ccr_o (ccr_o), .sp_o (sp_o)
    );

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "pc", {16'h0, pc_o}, {16'h0, m_pc});
        chk(tag, "acc", {24'h0, acc_o}, {24'h0, m_a});
        chk(tag, "idx", {24'h0, idx_o}, {24'h0, m_x});
        chk(tag, "ccr", {24'h0, ccr_o}, {24'h0, m_ccr});
        chk(tag, "sp", {16'h0, sp_o}, {16'h0, m_sp});
    endtask

    // Runs one operation and compares the ports every cycle against the model.
    task automatic run_op(input logic [7:0] opc, input int poke_k, input logic [7:0] poke_op, input string tag);
        int n;
        logic [15:0] ret;
        logic [15:0] waddr [5];
        logic [7:0]  wdat [5];
        logic [15:0] e_pc, e_sp;
        logic [7:0]  e_a, e_x, e_ccr;
        e_pc = m_pc; e_sp = m_sp; e_a = m_a; e_x = m_x; e_ccr = m_ccr;
        case (opc)
            8'h83: begin
                n = 11;
                ret = m_pc + 16'd1;
                wdat[0] = ret[7:0]; wdat[1] = ret[15:8]; wdat[2] = m_x; wdat[3] = m_a; wdat[4] = m_ccr;
                for (int i = 0; i < 5; i++) waddr[i] = m_sp - 16'(i);
                e_sp = m_sp - 16'd5;
                e_ccr = m_ccr | 8'h08;
                e_pc = {rd(VEC), rd(VEC + 16'd1)};
            end
            8'h80: begin
                n = 9;
                e_ccr = rd(m_sp + 16'd1);
                e_a   = rd(m_sp + 16'd2);
                e_x   = rd(m_sp + 16'd3);
                e_pc  = {rd(m_sp + 16'd4), rd(m_sp + 16'd5)};
                e_sp  = m_sp + 16'd5;
            end
            8'h81: begin
                n = 6;
                e_pc = {rd(m_sp + 16'd1), rd(m_sp + 16'd2)};
                e_sp = m_sp + 16'd2;
            end
            8'h9C: begin
                n = 1;
                e_sp = {m_sp[15:8], 8'hFF};
            end
            default: n = 1;
        endcase
        @(negedge clk);
        op_code = opc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= n; k++) begin
            bit wr_exp;
            wr_exp = (opc == 8'h83) && (k >= 2) && (k <= 6);
            chk("R6", $sformatf("%s done cycle %0d", tag, k), {31'h0, done}, {31'h0, (k == n)});
            chk("R9", $sformatf("%s we cycle %0d", tag, k), {31'h0, mem_we}, {31'h0, wr_exp});
            if (wr_exp && mem_we) begin
                chk("R9", $sformatf("%s push addr %0d", tag, k), {16'h0, mem_addr}, {16'h0, waddr[k-2]});
                chk(tag, $sformatf("push data %0d", k), {24'h0, mem_wdata}, {24'h0, wdat[k-2]});
            end
            if (k == poke_k) begin
                start = 1'b1;
                op_code = poke_op;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        m_pc = e_pc; m_sp = e_sp; m_a = e_a; m_x = e_x; m_ccr = e_ccr;
        chk("R6", $sformatf("%s done after end", tag), {31'h0, done}, 32'h0);
        check_regs(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        mem[16'h0100] = 8'hC2; mem[16'h0101] = 8'h3C; mem[16'h0102] = 8'h7E;
        mem[16'h0103] = 8'h12; mem[16'h0104] = 8'h34;
        mem[16'h0200] = 8'h56; mem[16'h0201] = 8'h78;
        mem[VEC] = 8'hAB; mem[VEC + 16'd1] = 8'hCD;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        m_pc = 16'h0000; m_sp = 16'h00FF; m_a = 8'h00; m_x = 8'h00; m_ccr = 8'h08;
        check_regs("R8");
        chk("R8", "done", {31'h0, done}, 32'h0);
        chk("R8", "we", {31'h0, mem_we}, 32'h0);

        run_op(8'h80, 0, 8'h00, "R3");   // full context pull, SP crosses into 0x01xx
        run_op(8'h9C, 0, 8'h00, "R5");   // high byte 0x01 kept
        run_op(8'h83, 0, 8'h00, "R1");   // push frame, mask set, vector load
        run_op(8'h81, 0, 8'h00, "R4");   // pull PC only
        run_op(8'h80, 0, 8'h00, "R3");   // second frame, bytes from earlier pushes
        run_op(8'h9D, 0, 8'h00, "R7");   // unknown code
        run_op(8'h00, 0, 8'h00, "R7");   // unknown code
        run_op(8'h81, 3, 8'h9C, "R10");  // start mid-sequence ignored
        run_op(8'h83, 5, 8'h80, "R2");   // vector fetch, mask set
        run_op(8'h9C, 0, 8'h00, "R5");   // SP high byte kept after wrap
        run_op(8'h80, 2, 8'h83, "R10");  // start during pulls ignored

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule